// File: doc/BRIEF.md
# Result-Latency Scoreboard with Consumer-Aware Bypasses

This block tracks, for every architectural register, how many cycles remain until the value written by its most recent producer can be consumed. When a producer issues, the entry for its destination register is loaded with a down-counter derived from the producer's class and the class is remembered. Each cycle every live counter steps toward zero.

For the consumer presented in the same cycle, the block examines each of its source registers and decides whether that operand may be used now. The answer depends on both ends of the dependency. The consumer's class matters as well as the producer's, and so does whether the operand is the data input of a store. Store data, integer branches after a compare, floating-point arithmetic chains and graphics chains all see shorter latencies than the default. The consumer may issue in the same cycle as its producer when the effective latency is zero, so the producer being issued this cycle is checked as well. The output is one ready bit per source and an overall ready/stall bit, for the issue logic to act on.

Top module: `lat_scoreboard`

## Requirements
- R1: Class codes on `prod_class`/`cons_class`: 0 int ALU/shift, 1 int compare, 2 cond move, 3 unsigned load, 4 signed load, 5 store, 6 branch, 7 FP move, 8 FP compare, 9 FP cond move, 10 FP add/sub, 11 FP multiply, 12 graphics add/logic single, 13 graphics add/logic double, 14 graphics mul/pack single, 15 graphics mul/pack double, 16 pixel distance, 17 FP divide/sqrt single, 18 FP divide/sqrt double. After a synchronous active-low reset every register reads as ready.
- R2: A producer issued in cycle t makes its register ready for a consumer in cycle t+k exactly when k is at least the effective latency. By default the latency is 1 for classes 0, 1, 5, 6, 7 and 8, 2 for classes 2, 3 and 9, 3 for class 4 and 4 for classes 10 and 11.
- R3: A producer of class 10 or 11 feeding a consumer of class 10 or 11 has latency 3.
- R4: When the consumer is a store (5) and the operand's position equals `cons_data_idx`, producers of class 0, 1, 7, 9, 10 or 11 have latency 0. Store address operands (any other position) keep the default.
- R5: Divide/sqrt producers have latency 13 (single) and 23 (double). They never get the zero store-data bypass. Feeding class 10 or 11, their latency is 12 and 22 respectively.
- R6: A compare (1) feeding a branch (6) has latency 0. An FP compare (8) feeding a branch keeps latency 1.
- R7: Graphics add/logic ops have latency 2, reduced to 1 when feeding a graphics add/logic op of the same precision.
- R8: Graphics mul/pack and pixel-distance ops have latency 4. The latency is 3 when they feed a graphics add/logic op, single-to-single, double-to-double, with pixel distance feeding either. Pixel distance feeding pixel distance has latency 1.
- R9: `cons_data_idx` has no effect unless the consumer class is store.
- R10: Register 0 never holds a pending result and always reads as ready, even right after a producer targets it.
- R11: A newer producer to a register replaces the older one's timing completely, whether the new latency is shorter or longer.
- R12: `src_ready[s]` reports source s, with source s at bits [5s+4:5s] of `cons_srcs`. `cons_ready` is high only when every source is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_valid | input | 1 | A producer issues this cycle |
| prod_class | input | 5 | Producer class code |
| prod_dst | input | 5 | Producer destination register |
| cons_class | input | 5 | Consumer class code |
| cons_srcs | input | 10 | Consumer source registers, 5 bits each |
| cons_data_idx | input | 1 | Which source position is store data |
| src_ready | output | 2 | Per-source ready |
| cons_ready | output | 1 | All sources ready (low means stall) |

## Verification
A producer is registered at the rising edge that ends its issue cycle. The ready outputs are combinational from the consumer inputs, so a dependency with effective latency L is due exactly L cycles after the issue cycle, or in the issue cycle itself when L is zero. For every latency rule, the bench drives inputs just after the falling edge, samples 1 ns later, and checks each cycle from issue through cycle L. It expects a stall before cycle L and ready at cycle L, so a latency off by one in either direction is seen. Before each vector, the bench lets more cycles pass than the longest latency, so no earlier producer can affect the result.

// File: rtl/sb_pkg.sv
// Package: class codes and latency rules for the result-latency scoreboard.
// Assumes class codes are 5 bits wide and the longest latency fits SB_CNT_W bits.
package sb_pkg;

    localparam int SB_CLS_W = 5;
    localparam int SB_LAT_MAX = 23;
    localparam int SB_CNT_W = $clog2(SB_LAT_MAX);

    typedef enum logic [SB_CLS_W-1:0] {
        CL_ALU    = 5'd0,
        CL_CMP    = 5'd1,
        CL_CMOV   = 5'd2,
        CL_LDU    = 5'd3,
        CL_LDS    = 5'd4,
        CL_STORE  = 5'd5,
        CL_BRANCH = 5'd6,
        CL_FMOV   = 5'd7,
        CL_FCMP   = 5'd8,
        CL_FCMOV  = 5'd9,
        CL_FADD   = 5'd10,
        CL_FMUL   = 5'd11,
        CL_GADD_S = 5'd12,
        CL_GADD_D = 5'd13,
        CL_GMUL_S = 5'd14,
        CL_GMUL_D = 5'd15,
        CL_PDIST  = 5'd16,
        CL_FDIV_S = 5'd17,
        CL_FDIV_D = 5'd18
    } sb_cls_e;

    // Default latency of a producer class (R2, R5, R7, R8).
    function automatic int unsigned base_lat(sb_cls_e p);
        case (p)
            CL_CMOV, CL_LDU, CL_FCMOV, CL_GADD_S, CL_GADD_D: return 2;
            CL_LDS:                                          return 3;
            CL_FADD, CL_FMUL, CL_GMUL_S, CL_GMUL_D, CL_PDIST: return 4;
            CL_FDIV_S:                                       return 13;
            CL_FDIV_D:                                       return 23;
            default:                                         return 1;
        endcase
    endfunction

    // True for FP add/sub and FP multiply.
    function automatic logic fp_arith(sb_cls_e c);
        return (c == CL_FADD) || (c == CL_FMUL);
    endfunction

    // Effective latency of a producer/consumer pair (R3..R9).
    function automatic int unsigned eff_lat(sb_cls_e p, sb_cls_e c, logic is_data);
        int unsigned l;
        l = base_lat(p);
        if (c == CL_STORE) begin
            if (is_data && (p inside {CL_ALU, CL_CMP, CL_FMOV, CL_FCMOV, CL_FADD, CL_FMUL}))
                l = 0;
        end else if (c == CL_BRANCH) begin
            if (p == CL_CMP) l = 0;
        end else if (fp_arith(c)) begin
            if (fp_arith(p))            l = 3;
            else if (p == CL_FDIV_S)    l = 12;
            else if (p == CL_FDIV_D)    l = 22;
        end else if (c == CL_GADD_S) begin
            if (p == CL_GADD_S)                          l = 1;
            else if (p == CL_GMUL_S || p == CL_PDIST)    l = 3;
        end else if (c == CL_GADD_D) begin
            if (p == CL_GADD_D)                          l = 1;
            else if (p == CL_GMUL_D || p == CL_PDIST)    l = 3;
        end else if (c == CL_PDIST) begin
            if (p == CL_PDIST) l = 1;
        end
        return l;
    endfunction

endpackage

// File: rtl/sb_entry.sv
// Module: one register's scoreboard entry.
// Holds the cycles remaining until the default latency of the last producer
// has elapsed, plus that producer's class. Load has priority over countdown.
// Assumes load_cnt is the producer's default latency minus one.
module sb_entry
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SB_CNT_W-1:0] load_cnt,
    input  sb_cls_e             load_cls,
    output logic [SB_CNT_W-1:0] rem,
    output sb_cls_e             cls
);

    // Load on producer issue, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            cls <= CL_ALU;
        end else if (load) begin
            rem <= load_cnt;
            cls <= load_cls;
        end else if (rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    // R2: an idle pending entry steps down by one each cycle.
    a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem != '0) |=> (rem == $past(rem) - 1'b1));

    // R11: a newer producer replaces whatever was pending.
    a_r11_newest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rem == $past(load_cnt) && cls == $past(load_cls)));

endmodule

// File: rtl/sb_src_check.sv
// Module: readiness of one consumer source operand.
// Looks at the producer issuing this cycle first (same-cycle bypass), then at
// the stored entry. Register 0 is always ready.
// Assumes every effective latency is no larger than the default latency.
module sb_src_check
    import sb_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    src,
    input  logic                is_data,
    input  sb_cls_e             cons_cls,
    input  logic                prod_valid,
    input  sb_cls_e             prod_cls,
    input  logic [REG_W-1:0]    prod_dst,
    input  logic [SB_CNT_W-1:0] ent_rem,
    input  sb_cls_e             ent_cls,
    output logic                ready
);

    logic hit_now;
    int unsigned thr;

    assign hit_now = prod_valid && (prod_dst == src);

    // Compare remaining cycles with the slack the bypass rules allow.
    always_comb begin
        thr = base_lat(ent_cls) - eff_lat(ent_cls, cons_cls, is_data);
        if (src == '0)
            ready = 1'b1;
        else if (hit_now)
            ready = (eff_lat(prod_cls, cons_cls, is_data) == 0);
        else
            ready = (int'(ent_rem) <= thr);
    end

    // R6: a branch may use a compare result from the same cycle.
    a_r6_cmp_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_now && prod_cls == CL_CMP && cons_cls == CL_BRANCH) |-> ready);

    // R2: a load result is never usable in its issue cycle.
    a_r2_load_not_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_now && src != '0 && (prod_cls == CL_LDU || prod_cls == CL_LDS)) |-> !ready);

    // R5: divide/sqrt results never take the zero store-data bypass.
    a_r5_div_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_now && src != '0 && (prod_cls == CL_FDIV_S || prod_cls == CL_FDIV_D)) |-> !ready);

    // R10: register 0 is ready whatever is issuing.
    a_r10_reg0_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0 && prod_valid && prod_dst == '0) |-> ready);

endmodule

// File: rtl/lat_scoreboard.sv
// Module: result-latency scoreboard (top).
// One entry per register (register 0 hard-wired empty), one checker per
// consumer source. Outputs are combinational from consumer inputs and state.
// Assumes at most one producer issues per cycle.
module lat_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_SRC  = 2,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prod_valid,
    input  logic [SB_CLS_W-1:0]      prod_class,
    input  logic [REG_W-1:0]         prod_dst,
    input  logic [SB_CLS_W-1:0]      cons_class,
    input  logic [NUM_SRC*REG_W-1:0] cons_srcs,
    input  logic [IDX_W-1:0]         cons_data_idx,
    output logic [NUM_SRC-1:0]       src_ready,
    output logic                     cons_ready
);

    sb_cls_e             pcls;
    sb_cls_e             ccls;
    logic [SB_CNT_W-1:0] load_cnt;
    logic [SB_CNT_W-1:0] rem_q [NUM_REGS];
    sb_cls_e             cls_q [NUM_REGS];

    assign pcls     = sb_cls_e'(prod_class);
    assign ccls     = sb_cls_e'(cons_class);
    assign load_cnt = SB_CNT_W'(base_lat(pcls) - 1);

    // Register entries; entry 0 never holds a pending result.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            assign rem_q[r] = '0;
            assign cls_q[r] = CL_ALU;
        end else begin : g_ent
            sb_entry u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (prod_valid && (prod_dst == REG_W'(r))),
                .load_cnt (load_cnt),
                .load_cls (pcls),
                .rem      (rem_q[r]),
                .cls      (cls_q[r])
            );
        end
    end

    // Per-source readiness.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [REG_W-1:0] sidx;
        assign sidx = cons_srcs[s*REG_W +: REG_W];
        sb_src_check #(.REG_W(REG_W)) u_chk (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (sidx),
            .is_data    (cons_data_idx == IDX_W'(s)),
            .cons_cls   (ccls),
            .prod_valid (prod_valid),
            .prod_cls   (pcls),
            .prod_dst   (prod_dst),
            .ent_rem    (rem_q[sidx]),
            .ent_cls    (cls_q[sidx]),
            .ready      (src_ready[s])
        );
    end

    // Stall unless every operand is ready.
    assign cons_ready = &src_ready;

    // R12: no consumer is released while any operand stalls.
    a_r12_all_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cons_ready |-> (src_ready == '1));

endmodule

// File: tb/tb_lat_scoreboard.sv
// Bench: table of latency vectors walked by one loop, then directed tests.
module tb_lat_scoreboard;
    import sb_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prod_valid = 1'b0;
    logic [4:0] prod_class = '0;
    logic [4:0] prod_dst = '0;
    logic [4:0] cons_class = '0;
    logic [9:0] cons_srcs = '0;
    logic [0:0] cons_data_idx = '0;
    logic [1:0] src_ready;
    logic       cons_ready;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lat_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_class(prod_class),
        .prod_dst(prod_dst), .cons_class(cons_class), .cons_srcs(cons_srcs),
        .cons_data_idx(cons_data_idx), .src_ready(src_ready), .cons_ready(cons_ready)
    );

    typedef struct packed {
        logic [4:0] pc;
        logic [4:0] cc;
        logic       slot;
        logic       didx;
        logic [4:0] lat;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        // R2 defaults
        '{5'd0,  5'd0,  1'b0, 1'b0, 5'd1,  4'd2},
        '{5'd2,  5'd0,  1'b0, 1'b0, 5'd2,  4'd2},
        '{5'd3,  5'd0,  1'b1, 1'b0, 5'd2,  4'd2},
        '{5'd4,  5'd0,  1'b0, 1'b0, 5'd3,  4'd2},
        '{5'd10, 5'd7,  1'b0, 1'b0, 5'd4,  4'd2},
        '{5'd11, 5'd0,  1'b0, 1'b0, 5'd4,  4'd2},
        '{5'd8,  5'd0,  1'b0, 1'b0, 5'd1,  4'd2},
        '{5'd9,  5'd7,  1'b0, 1'b0, 5'd2,  4'd2},
        // R3 FP arithmetic chains
        '{5'd10, 5'd11, 1'b0, 1'b0, 5'd3,  4'd3},
        '{5'd11, 5'd10, 1'b1, 1'b0, 5'd3,  4'd3},
        // R4 store data versus address
        '{5'd0,  5'd5,  1'b1, 1'b1, 5'd0,  4'd4},
        '{5'd11, 5'd5,  1'b0, 1'b0, 5'd0,  4'd4},
        '{5'd9,  5'd5,  1'b1, 1'b1, 5'd0,  4'd4},
        '{5'd0,  5'd5,  1'b0, 1'b1, 5'd1,  4'd4},
        '{5'd3,  5'd5,  1'b1, 1'b1, 5'd2,  4'd4},
        // R5 divide/sqrt
        '{5'd17, 5'd5,  1'b0, 1'b0, 5'd13, 4'd5},
        '{5'd18, 5'd11, 1'b0, 1'b0, 5'd22, 4'd5},
        '{5'd17, 5'd0,  1'b0, 1'b0, 5'd13, 4'd5},
        // R6 branch after compare
        '{5'd1,  5'd6,  1'b0, 1'b0, 5'd0,  4'd6},
        '{5'd8,  5'd6,  1'b0, 1'b0, 5'd1,  4'd6},
        // R7 graphics add/logic
        '{5'd12, 5'd12, 1'b0, 1'b0, 5'd1,  4'd7},
        '{5'd13, 5'd12, 1'b0, 1'b0, 5'd2,  4'd7},
        '{5'd12, 5'd0,  1'b0, 1'b0, 5'd2,  4'd7},
        // R8 graphics multiply and pixel distance
        '{5'd14, 5'd12, 1'b0, 1'b0, 5'd3,  4'd8},
        '{5'd15, 5'd12, 1'b0, 1'b0, 5'd4,  4'd8},
        '{5'd16, 5'd13, 1'b0, 1'b0, 5'd3,  4'd8},
        '{5'd16, 5'd16, 1'b0, 1'b0, 5'd1,  4'd8},
        '{5'd16, 5'd10, 1'b0, 1'b0, 5'd4,  4'd8},
        // R9 data index ignored for a non-store consumer
        '{5'd0,  5'd7,  1'b1, 1'b1, 5'd1,  4'd9}
    };

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input logic [1:0] got, input logic [1:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
        end
    endtask

    // Idle cycles with no producer and all sources on register 0.
    task automatic idle(input int n);
        prod_valid = 1'b0;
        cons_srcs  = '0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Issue one producer and sweep the consumer from the issue cycle to the due cycle.
    task automatic run_vec(input vec_t v, input logic [4:0] r);
        idle(26);
        prod_valid = 1'b1;
        prod_class = v.pc;
        prod_dst   = r;
        for (int k = 0; k <= int'(v.lat); k++) begin
            if (k > 0) begin
                @(negedge clk);
                prod_valid = 1'b0;
            end
            cons_class    = v.cc;
            cons_data_idx = v.didx;
            cons_srcs     = v.slot ? {r, 5'd0} : {5'd0, r};
            #1;
            check({1'b0, cons_ready}, {1'b0, k >= int'(v.lat)},
                  $sformatf("R%0d vec pc=%0d cc=%0d k=%0d", v.req, v.pc, v.cc, k));
        end
        prod_valid = 1'b0;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog: got=hung expected=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: after reset all registers are ready
        cons_class = 5'd0;
        cons_srcs  = {5'd31, 5'd5};
        #1;
        check(src_ready, 2'b11, "R1 reset state");

        // Table walk
        for (int i = 0; i < NV; i++) run_vec(VEC[i], 5'((i % 31) + 1));

        // R1: reset mid-flight clears a pending signed load
        idle(26);
        prod_valid = 1'b1; prod_class = 5'd4; prod_dst = 5'd7;
        @(negedge clk);
        prod_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; cons_class = 5'd0; cons_srcs = {5'd0, 5'd7};
        #1;
        check({1'b0, cons_ready}, 2'b01, "R1 reset clears pending");

        // R10: register 0 stays ready after a producer targets it
        idle(2);
        prod_valid = 1'b1; prod_class = 5'd4; prod_dst = 5'd0;
        cons_class = 5'd0; cons_srcs = 10'd0;
        #1;
        check({1'b0, cons_ready}, 2'b01, "R10 reg0 same cycle");
        @(negedge clk);
        prod_valid = 1'b0;
        #1;
        check({1'b0, cons_ready}, 2'b01, "R10 reg0 next cycle");

        // R11: shorter newer producer replaces a signed load
        idle(26);
        prod_valid = 1'b1; prod_class = 5'd4; prod_dst = 5'd9;
        cons_class = 5'd0; cons_srcs = {5'd0, 5'd9};
        #1;
        check({1'b0, cons_ready}, 2'b00, "R11 load issue cycle");
        @(negedge clk);
        prod_class = 5'd0;
        #1;
        check({1'b0, cons_ready}, 2'b00, "R11 alu issue cycle");
        @(negedge clk);
        prod_valid = 1'b0;
        #1;
        check({1'b0, cons_ready}, 2'b01, "R11 shorter overwrite ready");

        // R11: longer newer producer replaces an ALU op
        idle(26);
        prod_valid = 1'b1; prod_class = 5'd0; prod_dst = 5'd9;
        @(negedge clk);
        prod_class = 5'd10;
        @(negedge clk);
        prod_valid = 1'b0; cons_class = 5'd0; cons_srcs = {5'd0, 5'd9};
        #1;
        check({1'b0, cons_ready}, 2'b00, "R11 longer overwrite stalls");

        // R12: per-source reporting and AND of all sources
        idle(26);
        prod_valid = 1'b1; prod_class = 5'd4; prod_dst = 5'd3;
        @(negedge clk);
        prod_valid = 1'b0; cons_class = 5'd0; cons_srcs = {5'd6, 5'd3};
        #1;
        check(src_ready, 2'b10, "R12 source0 pending");
        check({1'b0, cons_ready}, 2'b00, "R12 consumer stalls");
        cons_srcs = {5'd3, 5'd6};
        #1;
        check(src_ready, 2'b01, "R12 source1 pending");
        idle(2);
        cons_srcs = {5'd3, 5'd6};
        #1;
        check({src_ready[0], cons_ready}, 2'b11, "R12 all ready");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule